// File: doc/BRIEF.md
# Geometry Emit Triangle Assembler

This block carries out the two vertex-emission instructions of a programmable geometry stage. A parameter-load strobe latches a 32-bit control word. An emit strobe takes a snapshot of the shader's output-register set and writes it into one of three vertex slots. The control word chooses the slot. When the word asks for it, the same emit also sends a triangle built from the three slots, in forward or reversed order.

Triangles leave through a valid/ready stream. While a triangle waits at the output and the consumer is not ready, a combinational stall tells the instruction sequencer to hold further emits. An emit that names the unused fourth slot changes nothing. It raises a one-cycle error pulse instead.

Top module: `geo_emit_asm`

## Requirements
- R1: After reset `triValid`, `stall` and `errFlag` are low and the latched control word is zero. With slot id 0, no triangle request and forward order, an emit then only stores.
- R2: A parameter-load strobe latches all of `paramWord`. Bit 22 is the reverse-order flag, bit 23 is the triangle request and bits 25:24 are the slot id. An emit uses the word latched before its own cycle, so a load in the same cycle affects only later emits.
- R3: An accepted emit whose slot id is 0, 1 or 2 copies `outRegs` into that slot and leaves the other two slots unchanged.
- R4: An accepted emit with slot id 3 stores nothing and sends no triangle. `errFlag` is high for exactly the next cycle.
- R5: An accepted emit with the triangle request set raises `triValid` in the next cycle. The triangle includes the vertex written by that same emit.
- R6: With the reverse flag clear, `triVtxA`, `triVtxB` and `triVtxC` carry slots 0, 1 and 2 in that order.
- R7: With the reverse flag set, `triVtxA`, `triVtxB` and `triVtxC` carry slots 2, 1 and 0 in that order.
- R8: While `triValid` is high and `triReady` is low, `triValid` and all three vertex outputs hold their values. After a handshake `triValid` falls in the next cycle unless a new triangle is loaded in the handshake cycle.
- R9: `stall` equals `triValid` and not `triReady` in the same cycle. An emit during a stall is ignored: no slot is written, no triangle is sent and no error is raised.
- R10: An accepted emit with the triangle request clear writes its slot and leaves `triValid` and the vertex outputs as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| paramLoad | input | 1 | Strobe: latch `paramWord` |
| paramWord | input | 32 | Emission control word |
| emitStb | input | 1 | Strobe: emit the current output-register snapshot |
| outRegs | input | VTX_W | Output-register snapshot of the shader |
| triReady | input | 1 | Consumer accepts the triangle |
| triValid | output | 1 | Triangle present on the vertex outputs |
| triVtxA | output | VTX_W | First vertex of the triangle |
| triVtxB | output | VTX_W | Second vertex of the triangle |
| triVtxC | output | VTX_W | Third vertex of the triangle |
| stall | output | 1 | Hold further emits |
| errFlag | output | 1 | One-cycle pulse after an emit with slot id 3 |

## Verification
The registered results are due one clock edge after the strobe that causes them: the latched word, the slot writes, `triValid` with its vertices, and the error pulse. `stall` is combinational in the same cycle as `triReady`. The bench keeps a behavioural model of the registered state and advances it at each rising edge from the inputs driven in that cycle. It drives inputs at the falling edge and compares every output one time unit later. So the registered outputs are checked against the model state from the edge just passed, and `stall` is checked against that state together with the `triReady` just driven.

// File: rtl/geo_emit_pkg.sv
package geo_emit_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_ID_W = 2;
  localparam int WIND_BIT = 22;
  localparam int PRIM_BIT = 23;
  localparam int SLOT_LO = 24;
  localparam int SLOT_HI = SLOT_LO + SLOT_ID_W - 1;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] slotWe;
    logic loadTri;
    logic reverse;
  } emit_strobe_t;
endpackage

// File: rtl/geo_emit_ctrl.sv
module geo_emit_ctrl
  import geo_emit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         paramLoad,
  input  logic [31:0]  paramWord,
  input  logic         emitStb,
  input  logic         triReady,
  output emit_strobe_t stb,
  output logic         triValid,
  output logic         stall,
  output logic         errFlag
);
  logic [31:0] paramReg;
  logic [SLOT_ID_W-1:0] slotId;
  logic accept;
  logic legal;
  logic unusedParamBits;

  assign slotId = paramReg[SLOT_HI:SLOT_LO];
  assign unusedParamBits = ^{paramReg[31:SLOT_HI+1], paramReg[WIND_BIT-1:0]};
  assign stall = triValid & ~triReady;
  assign accept = emitStb & ~stall;
  assign legal = (slotId < SLOT_ID_W'(NUM_SLOTS));

  genvar i;
  generate
    for (i = 0; i < NUM_SLOTS; i++) begin : g_we
      assign stb.slotWe[i] = accept & legal & (slotId == SLOT_ID_W'(i));
    end
  endgenerate

  assign stb.loadTri = accept & legal & paramReg[PRIM_BIT];
  assign stb.reverse = paramReg[WIND_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paramReg <= '0;
      triValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (paramLoad) paramReg <= paramWord;
      if (stb.loadTri) triValid <= 1'b1;
      else if (triReady) triValid <= 1'b0;
      errFlag <= accept & ~legal;
    end
  end

  AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.slotWe)); // R3
  AST_NO_LOAD_IN_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (stb.slotWe == '0 && !stb.loadTri)); // R9
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (triValid && !triReady) |=> triValid); // R8
  AST_ILLEGAL_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (emitStb && !stall && slotId == SLOT_ID_W'(NUM_SLOTS)) |-> (stb.slotWe == '0 && !stb.loadTri)); // R4
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (emitStb && !stall && slotId == SLOT_ID_W'(NUM_SLOTS)) |=> errFlag); // R4
endmodule

// File: rtl/geo_emit_dp.sv
module geo_emit_dp
  import geo_emit_pkg::*;
#(
  parameter int VTX_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  emit_strobe_t     stb,
  input  logic [VTX_W-1:0] outRegs,
  output logic [VTX_W-1:0] triVtxA,
  output logic [VTX_W-1:0] triVtxB,
  output logic [VTX_W-1:0] triVtxC
);
  logic [VTX_W-1:0] slotQ [NUM_SLOTS];
  logic [VTX_W-1:0] slotNext [NUM_SLOTS];

  genvar i;
  generate
    for (i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign slotNext[i] = stb.slotWe[i] ? outRegs : slotQ[i];
      always_ff @(posedge clk) begin
        if (!rstN) slotQ[i] <= '0;
        else slotQ[i] <= slotNext[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      triVtxA <= '0;
      triVtxB <= '0;
      triVtxC <= '0;
    end else if (stb.loadTri) begin
      triVtxA <= stb.reverse ? slotNext[NUM_SLOTS-1] : slotNext[0];
      triVtxB <= slotNext[1];
      triVtxC <= stb.reverse ? slotNext[0] : slotNext[NUM_SLOTS-1];
    end
  end

  AST_TRI_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadTri |=> ($stable(triVtxA) && $stable(triVtxB) && $stable(triVtxC))); // R8
endmodule

// File: rtl/geo_emit_asm.sv
module geo_emit_asm
  import geo_emit_pkg::*;
#(
  parameter int VTX_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             paramLoad,
  input  logic [31:0]      paramWord,
  input  logic             emitStb,
  input  logic [VTX_W-1:0] outRegs,
  input  logic             triReady,
  output logic             triValid,
  output logic [VTX_W-1:0] triVtxA,
  output logic [VTX_W-1:0] triVtxB,
  output logic [VTX_W-1:0] triVtxC,
  output logic             stall,
  output logic             errFlag
);
  emit_strobe_t stb;

  geo_emit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .paramLoad(paramLoad), .paramWord(paramWord),
    .emitStb(emitStb), .triReady(triReady), .stb(stb),
    .triValid(triValid), .stall(stall), .errFlag(errFlag)
  );

  geo_emit_dp #(.VTX_W(VTX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .outRegs(outRegs),
    .triVtxA(triVtxA), .triVtxB(triVtxB), .triVtxC(triVtxC)
  );
endmodule

// File: tb/sim_geo_emit_asm.sv
module sim_geo_emit_asm;
  localparam int CLK_P = 10;

  logic clk = 0;
  logic rstN = 0;
  logic paramLoad = 0;
  logic [31:0] paramWord = 0;
  logic emitStb = 0;
  logic [31:0] outRegs = 0;
  logic triReady = 0;
  logic triValid, stall, errFlag;
  logic [31:0] triVtxA, triVtxB, triVtxC;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string scen = "R1";

  logic [31:0] mParam;
  logic [31:0] mSlot [3];
  logic [31:0] mTri [3];
  logic mValid, mErr, mRev;

  always #(CLK_P/2) clk = ~clk;

  geo_emit_asm #(.VTX_W(32)) u0 (
    .clk(clk), .rstN(rstN), .paramLoad(paramLoad), .paramWord(paramWord),
    .emitStb(emitStb), .outRegs(outRegs), .triReady(triReady),
    .triValid(triValid), .triVtxA(triVtxA), .triVtxB(triVtxB), .triVtxC(triVtxC),
    .stall(stall), .errFlag(errFlag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pw(input bit rev, input bit prim, input int sid);
    logic [31:0] w;
    w = 32'h00ab_cd12;
    w[22] = rev;
    w[23] = prim;
    w[25:24] = sid[1:0];
    return w;
  endfunction

  // One cycle: drive at falling edge, compare, advance model at rising edge.
  task automatic cyc(input bit ld, input logic [31:0] w, input bit em, input logic [31:0] v, input bit rdy);
    bit mStall, fire;
    int sid;
    paramLoad = ld; paramWord = w; emitStb = em; outRegs = v; triReady = rdy;
    #1;
    mStall = mValid && !rdy;
    chk(stall === mStall, "R9", {31'b0, stall}, {31'b0, mStall});
    chk(triValid === mValid, scen, {31'b0, triValid}, {31'b0, mValid});
    chk(errFlag === mErr, "R4", {31'b0, errFlag}, {31'b0, mErr});
    if (mValid) begin
      chk(triVtxA === mTri[0], mRev ? "R7" : "R6", triVtxA, mTri[0]);
      chk(triVtxB === mTri[1], mRev ? "R7" : "R6", triVtxB, mTri[1]);
      chk(triVtxC === mTri[2], mRev ? "R7" : "R6", triVtxC, mTri[2]);
    end
    fire = em && !mStall;
    sid = int'(mParam[25:24]);
    mErr = fire && sid == 3;
    if (fire && sid < 3) mSlot[sid] = v;
    if (fire && sid < 3 && mParam[23]) begin
      mValid = 1;
      mRev = mParam[22];
      mTri[0] = mRev ? mSlot[2] : mSlot[0];
      mTri[1] = mSlot[1];
      mTri[2] = mRev ? mSlot[0] : mSlot[2];
    end else if (rdy) mValid = 0;
    if (ld) mParam = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    mParam = 0; mValid = 0; mErr = 0; mRev = 0;
    for (int k = 0; k < 3; k++) begin mSlot[k] = 0; mTri[k] = 0; end
    repeat (2) @(negedge clk);
    #1;
    chk(triValid === 1'b0 && stall === 1'b0 && errFlag === 1'b0, "R1",
        {29'b0, triValid, stall, errFlag}, 32'h0);
    rstN = 1;
    @(negedge clk);
    // R1: zero word -> slot 0, store only
    scen = "R1";
    cyc(0, 0, 1, 32'h1111_0000, 1);
    cyc(0, 0, 0, 0, 1);
    // R3 / R10: fill slots without triangle request
    scen = "R10";
    for (int k = 0; k < 3; k++) begin
      cyc(1, pw(0, 0, k), 0, 0, 1);
      cyc(0, 0, 1, 32'hA000_0000 + k, 1);
    end
    // R5 / R6: forward triangle, new vertex in slot 2
    scen = "R5";
    cyc(1, pw(0, 1, 2), 0, 0, 1);
    cyc(0, 0, 1, 32'hC0DE_0002, 1);
    cyc(0, 0, 0, 0, 1);
    // R7: reversed order
    cyc(1, pw(1, 1, 0), 0, 0, 1);
    cyc(0, 0, 1, 32'hBEEF_0000, 1);
    cyc(0, 0, 0, 0, 1);
    // R2: load in same cycle as emit uses old word (reverse, prim, slot 0)
    scen = "R2";
    cyc(1, pw(0, 0, 1), 1, 32'h2222_0000, 1);
    cyc(0, 0, 1, 32'h2222_0001, 1);
    cyc(0, 0, 0, 0, 1);
    // R4: illegal slot id
    scen = "R4";
    cyc(1, pw(0, 1, 3), 0, 0, 1);
    cyc(0, 0, 1, 32'hDEAD_DEAD, 1);
    cyc(0, 0, 0, 0, 1);
    // R8 / R9: backpressure; emits during stall ignored
    scen = "R8";
    cyc(1, pw(0, 1, 1), 0, 0, 0);
    cyc(0, 0, 1, 32'h3333_0001, 0);
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 32'h9999_0000 + k, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    // R3: show slot 1 was not touched during the stall
    scen = "R3";
    cyc(1, pw(1, 1, 0), 0, 0, 1);
    cyc(0, 0, 1, 32'h4444_0000, 1);
    cyc(0, 0, 0, 0, 0);
    // R8: back-to-back triangle on handshake cycle
    scen = "R8";
    cyc(0, 0, 1, 32'h5555_0000, 1);
    cyc(0, 0, 1, 32'h5555_0001, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule